// File: doc/BRIEF.md
# Clock-Enable Low-Power Sequencer for a DDR2 Memory Controller

This block sits in a DDR2 memory controller and owns the clock-enable pin of the attached device. It takes single-cycle requests to enter power-down or self-refresh, plus a wake request. It also takes a status flag that is high while any bank holds an open row, and a flag that marks a read or write burst in flight. From these it chooses the kind of low-power state and drives the clock enable. It emits the refresh strobe that must go with self-refresh entry, and a run of NOP strobes while the device recovers on exit.

The kind of power-down follows the bank state. If every bank is precharged, dropping the clock enable gives a precharge power-down. If any row is open, it gives an active power-down. Self-refresh is allowed only with every bank idle, and the clock enable never falls while a burst is in flight. Entry requests that arrive during a burst are remembered and acted on as soon as the burst ends.

A free-running timer independent of the low-power states raises a one-cycle refresh-due pulse at a fixed period. That period is derived from the clock period and the 7.8 µs maximum average refresh interval.

Top module: `cke_pwr_ctrl`

## Requirements
- R1: After reset, cke is 1, mode is 00, ready is 1, and cmd_ref, cmd_nop and ref_due are 0.
- R2: A pd_req sampled in the active state with bank_open=0 and burst_busy=0 drives cke to 0 and mode to 01 (precharge power-down) on that edge, with ready 0.
- R3: A pd_req sampled in the active state with bank_open=1 and burst_busy=0 drives cke to 0 and mode to 10 (active power-down) on that edge.
- R4: An sr_req sampled in the active state with bank_open=0 and burst_busy=0 drives cke to 0 and mode to 11 on that edge, with cmd_ref high for exactly that one cycle.
- R5: An sr_req sampled while bank_open=1 is discarded: cke stays 1 and mode stays 00.
- R6: While burst_busy=1, cke stays 1 and mode stays 00. An entry request seen during the burst is held and taken on the first edge that samples burst_busy=0.
- R7: A wake_req sampled in either power-down mode raises cke on that edge. cmd_nop then stays high for exactly PD_EXIT_CYCLES cycles (default 3), and on the following edge ready returns to 1 and mode to 00.
- R8: A wake_req sampled in self-refresh follows the same sequence as R7, with SR_EXIT_CYCLES NOP cycles (default 200).
- R9: ref_due is a one-cycle pulse repeating every REF_INTERVAL_PS/CLK_PERIOD_PS cycles (default 3120 cycles).
- R10: When sr_req and pd_req are sampled together with bank_open=0, self-refresh is entered (mode 11).
- R11: wake_req in the active state produces no cmd_nop and leaves ready at 1. pd_req and sr_req in a low-power mode leave mode and cke unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_req | input | 1 | Request to enter power-down (pulse) |
| sr_req | input | 1 | Request to enter self-refresh (pulse) |
| wake_req | input | 1 | Request to leave the current low-power mode (pulse) |
| bank_open | input | 1 | High while any bank has an open row |
| burst_busy | input | 1 | High while a read or write burst is in flight |
| cke | output | 1 | Clock-enable pin of the device |
| cmd_ref | output | 1 | Refresh command strobe for self-refresh entry |
| cmd_nop | output | 1 | NOP command strobe during exit recovery |
| mode | output | 2 | 00 active, 01 precharge PD, 10 active PD, 11 self-refresh |
| ready | output | 1 | Device usable for normal commands |
| ref_due | output | 1 | One-cycle periodic refresh-due pulse |

## Verification
Every output is registered, so entry results (cke, mode, cmd_ref) appear one edge after the request is sampled. The bench drives inputs just after a falling edge and checks at the next falling edge. For exits, the bench counts the cycles in which cmd_nop is high and the cycle in which ready comes back, and compares them with PD_EXIT_CYCLES or SR_EXIT_CYCLES and the edge after. Held requests are checked across several busy cycles and then on the first idle edge. The refresh period is measured between two consecutive ref_due pulses, so the reset offset does not matter.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;

    typedef enum logic [1:0] {
        MODE_ACT = 2'b00,
        MODE_PPD = 2'b01,
        MODE_APD = 2'b10,
        MODE_SR  = 2'b11
    } pwr_mode_e;

    typedef enum logic [2:0] {
        ST_ACT,
        ST_PPD,
        ST_APD,
        ST_SR,
        ST_EXIT
    } pwr_state_e;

    typedef struct packed {
        pwr_state_e state;
        pwr_mode_e  mode;
        logic       cke;
        logic       cmd_ref;
        logic       cmd_nop;
        logic       ready;
        logic       hold_pd;
        logic       hold_sr;
    } pwr_ctl_t;

endpackage

// File: rtl/cke_exit_timer.sv
module cke_exit_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = len;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CW'(1));

    // R7/R8: a zero-length recovery would never release the exit state
    assert_len_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (len != '0));

    // R7: once the last count is seen the counter is empty next cycle
    assert_last_drains_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !load) |=> (cnt_q == '0));
endmodule

// File: rtl/cke_refresh_timer.sv
module cke_refresh_timer #(
    parameter int PERIOD = 3120
) (
    input  logic clk,
    input  logic rst_n,
    output logic due
);
    localparam int TW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [TW-1:0] cnt_d, cnt_q;
    logic          due_d, due_q;

    always_comb begin
        due_d = (cnt_q == TW'(PERIOD - 1));
        cnt_d = due_d ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            due_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            due_q <= due_d;
        end
    end

    assign due = due_q;

    // R9: the pulse lasts one cycle
    assert_due_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        due_q |=> !due_q);
endmodule

// File: rtl/cke_pwr_ctrl.sv
module cke_pwr_ctrl
    import cke_pwr_pkg::*;
#(
    parameter int CLK_PERIOD_PS   = 2500,
    parameter int REF_INTERVAL_PS = 7800000,
    parameter int PD_EXIT_CYCLES  = 3,
    parameter int SR_EXIT_CYCLES  = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_req,
    input  logic       sr_req,
    input  logic       wake_req,
    input  logic       bank_open,
    input  logic       burst_busy,
    output logic       cke,
    output logic       cmd_ref,
    output logic       cmd_nop,
    output logic [1:0] mode,
    output logic       ready,
    output logic       ref_due
);
    localparam int REF_CYCLES = REF_INTERVAL_PS / CLK_PERIOD_PS;
    localparam int MAX_EXIT   = (SR_EXIT_CYCLES > PD_EXIT_CYCLES) ? SR_EXIT_CYCLES : PD_EXIT_CYCLES;
    localparam int EW         = $clog2(MAX_EXIT + 1);

    pwr_ctl_t      d, q;
    logic          exit_load;
    logic [EW-1:0] exit_len;
    logic          exit_last;
    logic          want_sr, want_pd;

    cke_exit_timer #(.CW(EW)) u_exit (
        .clk  (clk),
        .rst_n(rst_n),
        .load (exit_load),
        .len  (exit_len),
        .last (exit_last)
    );

    cke_refresh_timer #(.PERIOD(REF_CYCLES)) u_ref (
        .clk  (clk),
        .rst_n(rst_n),
        .due  (ref_due)
    );

    always_comb begin
        d         = q;
        d.cmd_ref = 1'b0;
        exit_load = 1'b0;
        exit_len  = EW'(PD_EXIT_CYCLES);
        want_sr   = sr_req | q.hold_sr;
        want_pd   = pd_req | q.hold_pd;
        case (q.state)
            ST_ACT: begin
                if (burst_busy) begin
                    d.hold_sr = want_sr;
                    d.hold_pd = want_pd;
                end else begin
                    d.hold_sr = 1'b0;
                    d.hold_pd = 1'b0;
                    if (want_sr && !bank_open) begin
                        d.state   = ST_SR;
                        d.mode    = MODE_SR;
                        d.cke     = 1'b0;
                        d.cmd_ref = 1'b1;
                        d.ready   = 1'b0;
                    end else if (want_pd) begin
                        d.state   = bank_open ? ST_APD : ST_PPD;
                        d.mode    = bank_open ? MODE_APD : MODE_PPD;
                        d.cke     = 1'b0;
                        d.ready   = 1'b0;
                    end
                end
            end
            ST_PPD, ST_APD, ST_SR: begin
                if (wake_req) begin
                    exit_load = 1'b1;
                    exit_len  = (q.state == ST_SR) ? EW'(SR_EXIT_CYCLES) : EW'(PD_EXIT_CYCLES);
                    d.state   = ST_EXIT;
                    d.cke     = 1'b1;
                    d.cmd_nop = 1'b1;
                end
            end
            ST_EXIT: begin
                if (exit_last) begin
                    d.state   = ST_ACT;
                    d.mode    = MODE_ACT;
                    d.cmd_nop = 1'b0;
                    d.ready   = 1'b1;
                end
            end
            default: d.state = ST_ACT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state   <= ST_ACT;
            q.mode    <= MODE_ACT;
            q.cke     <= 1'b1;
            q.cmd_ref <= 1'b0;
            q.cmd_nop <= 1'b0;
            q.ready   <= 1'b1;
            q.hold_pd <= 1'b0;
            q.hold_sr <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cke     = q.cke;
    assign cmd_ref = q.cmd_ref;
    assign cmd_nop = q.cmd_nop;
    assign mode    = q.mode;
    assign ready   = q.ready;

    // R6: the clock enable never falls while a burst is in flight
    assert_cke_held_in_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_busy && cke) |=> cke);

    // R4: the refresh strobe coincides with the falling clock enable
    assert_ref_with_cke_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ref |-> (!cke && $past(cke)));

    // R4: self-refresh is only ever entered from an idle bank state
    assert_sr_only_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && $past(mode) != 2'b11) |-> !$past(bank_open));

    // R7: ready implies normal operation with the clock enable high
    assert_ready_means_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (cke && mode == 2'b00 && !cmd_nop));

    // R8: NOP recovery and refresh strobes never overlap
    assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_nop && cmd_ref));
endmodule

// File: tb/cke_pwr_ctrl_tb.sv
module cke_pwr_ctrl_tb;
    localparam int PD_N  = 3;
    localparam int SR_N  = 200;
    localparam int REF_N = 7800000 / 2500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_req = 1'b0, sr_req = 1'b0, wake_req = 1'b0;
    logic       bank_open = 1'b0, burst_busy = 1'b0;
    logic       cke, cmd_ref, cmd_nop, ready, ref_due;
    logic [1:0] mode;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cke_pwr_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .sr_req(sr_req),
        .wake_req(wake_req), .bank_open(bank_open), .burst_busy(burst_busy),
        .cke(cke), .cmd_ref(cmd_ref), .cmd_nop(cmd_nop), .mode(mode),
        .ready(ready), .ref_due(ref_due)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // wake and measure NOP cycles and the ready edge
    task automatic do_wake(input string req, input int n_exp);
        int nops = 0;
        int cyc  = 0;
        wake_req = 1'b1;
        step(1);
        wake_req = 1'b0;
        cyc = 1;
        check({req, " cke up on wake"}, cke, 1);
        while (!ready && cyc < 1000) begin
            if (cmd_nop) nops++;
            step(1);
            cyc++;
        end
        check({req, " nop cycles"}, nops, n_exp);
        check({req, " ready edge"}, cyc, n_exp + 1);
        check({req, " mode back"}, mode, 0);
        check({req, " nop off"}, cmd_nop, 0);
    endtask

    task automatic t_reset;
        check("R1 cke", cke, 1);
        check("R1 mode", mode, 0);
        check("R1 ready", ready, 1);
        check("R1 strobes", {cmd_ref, cmd_nop, ref_due}, 0);
    endtask

    task automatic t_pd_idle;
        bank_open = 1'b0;
        pd_req = 1'b1; step(1); pd_req = 1'b0;
        check("R2 cke", cke, 0);
        check("R2 mode", mode, 1);
        check("R2 ready", ready, 0);
        do_wake("R7 ppd", PD_N);
    endtask

    task automatic t_pd_open;
        bank_open = 1'b1;
        pd_req = 1'b1; step(1); pd_req = 1'b0;
        check("R3 cke", cke, 0);
        check("R3 mode", mode, 2);
        do_wake("R7 apd", PD_N);
        bank_open = 1'b0;
    endtask

    task automatic t_sr;
        sr_req = 1'b1; step(1); sr_req = 1'b0;
        check("R4 cke", cke, 0);
        check("R4 mode", mode, 3);
        check("R4 ref strobe", cmd_ref, 1);
        step(1);
        check("R4 ref one cycle", cmd_ref, 0);
        do_wake("R8 sr", SR_N);
    endtask

    task automatic t_sr_open;
        bank_open = 1'b1;
        sr_req = 1'b1; step(1); sr_req = 1'b0;
        check("R5 cke", cke, 1);
        check("R5 mode", mode, 0);
        bank_open = 1'b0;
        step(2);
        check("R5 not held", mode, 0);
    endtask

    task automatic t_busy;
        burst_busy = 1'b1;
        pd_req = 1'b1; step(1); pd_req = 1'b0;
        check("R6 cke busy", cke, 1);
        step(3);
        check("R6 mode busy", mode, 0);
        burst_busy = 1'b0;
        step(1);
        check("R6 held entry cke", cke, 0);
        check("R6 held entry mode", mode, 1);
        do_wake("R6 exit", PD_N);
    endtask

    task automatic t_both;
        pd_req = 1'b1; sr_req = 1'b1; step(1); pd_req = 1'b0; sr_req = 1'b0;
        check("R10 mode", mode, 3);
        do_wake("R10 exit", SR_N);
    endtask

    task automatic t_ignore;
        wake_req = 1'b1; step(1); wake_req = 1'b0;
        check("R11 no nop", cmd_nop, 0);
        check("R11 ready", ready, 1);
        pd_req = 1'b1; step(1); pd_req = 1'b0;
        sr_req = 1'b1; step(1); sr_req = 1'b0;
        check("R11 mode kept", mode, 1);
        check("R11 cke kept", cke, 0);
        do_wake("R11 exit", PD_N);
    endtask

    task automatic t_refresh;
        int gap = 0;
        int guard = 0;
        while (!ref_due && guard < 10000) begin step(1); guard++; end
        step(1);
        check("R9 width", ref_due, 0);
        gap = 1;
        while (!ref_due && gap < 10000) begin step(1); gap++; end
        check("R9 period", gap, REF_N);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_pd_idle();
        t_pd_open();
        t_sr();
        t_sr_open();
        t_busy();
        t_both();
        t_ignore();
        t_refresh();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=finished", cyc);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule